// File: doc/BRIEF.md
# Page Write-Protect Flag Sequencer

This block sits behind the bit-level front end of a serial two-wire EEPROM slave. It receives events that are already decoded from the bus: start, repeated start, stop, and received bytes with a one-cycle valid strobe. From these it recognises the transaction that sets or clears the write-protect flag of one eight-byte page. For each received byte it returns an acknowledge decision in the same cycle. It holds one protection flag per page in a register array.

A valid transaction has this shape: start, command byte, address byte, repeated start, the same command byte again, a control byte, eight data bytes, stop. The eight data bytes must be the current contents of the addressed page. The block reads the page through an asynchronous read port and compares each byte it receives against it. Page contents are only read, never written.

The flag changes only when the whole sequence completes cleanly. After a change, a busy window of `BUSY_CYC` cycles follows. During that window, new command bytes are refused.

Top module: `pgprot_seq`

## Requirements
- R1: Control byte 0x01 at the end of a complete, matching sequence sets the flag of page (address byte >> 3) on the cycle after the stop. No other flag changes.
- R2: Control byte 0x03 at the end of a complete, matching sequence clears the flag of page (address byte >> 3). No other flag changes.
- R3: In a valid sequence every byte is acknowledged: the first command byte, the address byte, the repeated command byte, the control byte and data bytes one to eight.
- R4: A command byte after the repeated start that differs from the first one is not acknowledged, and no flag changes.
- R5: A control byte other than 0x01 or 0x03 is not acknowledged, and no flag changes.
- R6: A data byte that differs from the stored byte at the same page offset (ascending from offset 0) is still acknowledged, but the flag update is cancelled.
- R7: Any of the following discards the request and leaves all flags unchanged: a stop after fewer than eight data bytes, a ninth data byte, or a start during the data phase. A ninth data byte is not acknowledged.
- R8: After an update, `busy` is high for exactly `BUSY_CYC` cycles. A command byte received while `busy` is high is not acknowledged.
- R9: After reset, all flags are 0, `busy` is 0, and a byte received outside a transaction is not acknowledged.
- R10: A first command byte is accepted only if its upper nibble equals `CMD_HI` (default 0xA) and bit 0 is 0. Otherwise it is not acknowledged and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start condition seen (one-cycle pulse) |
| ev_rstart | input | 1 | Repeated start seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| ack | output | 1 | Acknowledge decision for the byte on `rx_byte` in this cycle |
| mem_addr | output | ADDR_W | Read address into the page memory |
| mem_rdata | input | 8 | Read data for `mem_addr`, valid in the same cycle |
| prot_flags | output | 2**(ADDR_W-3) | Per-page protection flags |
| busy | output | 1 | Programming window after an update |

## Verification
The case that is hardest to reach is a transaction that gets all the way through, where every byte has been acknowledged, but one data byte does not match the page. Nothing at the acknowledge pin reveals the failure; only the flag array shows it, by not changing. The bench walks the mismatch through each of the eight offsets of a page whose flag would otherwise toggle. It then does the same for a seven-byte stop, a ninth byte and a start in the data phase. After every transaction it compares the full flag vector with an arithmetic model.

// File: rtl/pgprot_seq.sv
module pgprot_seq #(
  parameter int ADDR_W   = 8,
  parameter int BUSY_CYC = 64,
  parameter logic [3:0] CMD_HI = 4'hA
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_start,
  input  logic                        ev_rstart,
  input  logic                        ev_stop,
  input  logic                        rx_valid,
  input  logic [7:0]                  rx_byte,
  output logic                        ack,
  output logic [ADDR_W-1:0]           mem_addr,
  input  logic [7:0]                  mem_rdata,
  output logic [(1<<(ADDR_W-3))-1:0]  prot_flags,
  output logic                        busy
);
  localparam int PAGE_W = ADDR_W - 3;
  localparam int NPAGE  = 1 << PAGE_W;
  localparam int BW     = $clog2(BUSY_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD1, S_ADDR, S_RS, S_CMD2, S_CTRL, S_DATA} st_t;

  st_t              st;
  logic [7:0]       cmd_q;
  logic [PAGE_W-1:0] page_q;
  logic             set_q, bad_q;
  logic [3:0]       cnt_q;
  logic [BW-1:0]    bcnt;
  logic             ack_d, commit;

  wire cmd_ok  = (rx_byte[7:4] == CMD_HI) && !rx_byte[0];
  wire ctrl_ok = (rx_byte == 8'h01) || (rx_byte == 8'h03);

  assign busy     = (bcnt != '0);
  assign mem_addr = {page_q, cnt_q[2:0]};
  assign commit   = ev_stop && !ev_start && (st == S_DATA) && (cnt_q == 4'd8) && !bad_q;

  always_comb begin
    case (st)
      S_CMD1:  ack_d = cmd_ok && !busy;
      S_ADDR:  ack_d = 1'b1;
      S_CMD2:  ack_d = (rx_byte == cmd_q);
      S_CTRL:  ack_d = ctrl_ok;
      S_DATA:  ack_d = (cnt_q < 4'd8);
      default: ack_d = 1'b0;
    endcase
  end
  assign ack = rx_valid && ack_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cmd_q  <= '0;
      page_q <= '0;
      set_q  <= 1'b0;
      bad_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (ev_start) begin
      st <= S_CMD1;
    end else if (ev_rstart) begin
      st <= (st == S_RS) ? S_CMD2 : S_IDLE;
    end else if (ev_stop) begin
      st <= S_IDLE;
    end else if (rx_valid) begin
      if (!ack_d) st <= S_IDLE;
      else begin
        case (st)
          S_CMD1: begin cmd_q <= rx_byte; st <= S_ADDR; end
          S_ADDR: begin page_q <= rx_byte[ADDR_W-1:3]; st <= S_RS; end
          S_CMD2: st <= S_CTRL;
          S_CTRL: begin set_q <= (rx_byte == 8'h01); cnt_q <= '0; bad_q <= 1'b0; st <= S_DATA; end
          S_DATA: begin
            cnt_q <= cnt_q + 4'd1;
            if (rx_byte != mem_rdata) bad_q <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_flags <= '0;
      bcnt       <= '0;
    end else if (commit) begin
      prot_flags[page_q] <= set_q;
      bcnt               <= BW'(BUSY_CYC);
    end else if (busy) begin
      bcnt <= bcnt - 1'b1;
    end
  end

  p_flag_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_flags) |-> $past(ev_stop));
  p_one_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(prot_flags ^ $past(prot_flags)) <= 1);
  p_change_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_flags) |-> busy);
  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == S_CMD1 && rx_valid) |-> !ack);
  p_idle_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rx_valid) |-> !ack);
  p_ack_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> rx_valid);
  p_ninth_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && cnt_q == 4'd8 && rx_valid) |-> !ack);
  p_page_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && $past(st) == S_DATA) |-> $stable(page_q));
endmodule

// File: tb/pgprot_seq_bench.sv
module pgprot_seq_bench;
  localparam int AW = 6;
  localparam int NP = 1 << (AW - 3);
  localparam int BC = 20;

  logic clk = 0, rst_n = 0;
  logic ev_start = 0, ev_rstart = 0, ev_stop = 0, rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic ack, busy;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata;
  logic [NP-1:0] prot_flags, fm;
  logic [7:0] mem [0:(1<<AW)-1];
  int errors = 0, checks = 0;

  always #4 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  pgprot_seq #(.ADDR_W(AW), .BUSY_CYC(BC)) u_pgprot_seq (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .ack(ack), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .prot_flags(prot_flags), .busy(busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ev(input int k);
    @(negedge clk);
    ev_start = (k == 0); ev_rstart = (k == 1); ev_stop = (k == 2);
    @(posedge clk); #1;
    ev_start = 0; ev_rstart = 0; ev_stop = 0;
  endtask

  task automatic sendb(input logic [7:0] b, input logic exp, input string tag);
    @(negedge clk);
    rx_byte = b; rx_valid = 1;
    #1 chk(tag, ack, exp);
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic run(input logic [7:0] c1, input logic [7:0] c2, input logic [7:0] ad,
                     input logic [7:0] ctl, input int n, input int bad, input bit early, input string tag);
    bit ok, commit;
    int pg, nb;
    pg = ad[AW-1:3];
    commit = 0;
    ev(0);
    ok = (c1[7:4] == 4'hA) && !c1[0];
    sendb(c1, ok, {tag, " R10 cmd1"});
    if (ok) begin
      sendb(ad, 1, {tag, " R3 addr"});
      ev(1);
      ok = (c2 == c1);
      sendb(c2, ok, {tag, " R4 cmd2"});
      if (ok) begin
        ok = (ctl == 8'h01) || (ctl == 8'h03);
        sendb(ctl, ok, {tag, " R5 ctrl"});
        if (ok) begin
          for (int i = 0; i < n; i++)
            sendb(mem[pg*8 + (i % 8)] ^ ((i == bad) ? 8'h10 : 8'h00), i < 8, {tag, " R3 data"});
          if (early) ev(0);
          commit = (n == 8) && (bad < 0) && !early;
        end
      end
    end
    ev(2);
    if (commit) fm[pg] = (ctl == 8'h01);
    chk({tag, " R1 R2 R6 R7 flags"}, prot_flags, fm);
    chk({tag, " R8 busy start"}, busy, commit);
    nb = 0;
    while (busy && nb < 100) begin nb++; @(posedge clk); #1; end
    if (commit) chk({tag, " R8 busy length"}, nb, BC);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #400000 $display("FAIL watchdog expired");
    errors++; checks++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'((i * 37 + 5) & 255);
    fm = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R9 reset flags", prot_flags, 0);
    chk("R9 reset busy", busy, 0);
    sendb(8'hA0, 0, "R9 idle byte");
    for (int p = 0; p < NP; p++)
      run(8'hA0 | 8'((p << 1) & 14), 8'hA0 | 8'((p << 1) & 14), 8'(p*8 + p), 8'h01, 8, -1, 0, "R1 set");
    for (int p = 0; p < NP; p += 2)
      run(8'hA4, 8'hA4, 8'(p*8 + 7), 8'h03, 8, -1, 0, "R2 clear");
    run(8'hA2, 8'hA6, 8'h08, 8'h03, 8, -1, 0, "R4 mismatch");
    run(8'hA2, 8'hA0, 8'h08, 8'h03, 8, -1, 0, "R4 mismatch2");
    run(8'hA0, 8'hA0, 8'h08, 8'h02, 8, -1, 0, "R5 ctrl02");
    run(8'hA0, 8'hA0, 8'h08, 8'h00, 8, -1, 0, "R5 ctrl00");
    run(8'hA0, 8'hA0, 8'h08, 8'hFF, 8, -1, 0, "R5 ctrlFF");
    for (int b = 0; b < 8; b++)
      run(8'hA0, 8'hA0, 8'h18, 8'h03, 8, b, 0, "R6 bad data");
    run(8'hA0, 8'hA0, 8'h18, 8'h03, 7, -1, 0, "R7 short");
    run(8'hA0, 8'hA0, 8'h18, 8'h03, 9, -1, 0, "R7 long");
    run(8'hA0, 8'hA0, 8'h18, 8'h03, 8, -1, 1, "R7 early start");
    run(8'hA1, 8'hA1, 8'h00, 8'h01, 8, -1, 0, "R10 read bit");
    run(8'hB0, 8'hB0, 8'h00, 8'h01, 8, -1, 0, "R10 bad type");
    run(8'hA0, 8'hA0, 8'h00, 8'h01, 8, -1, 0, "R1 set page0");
    // R8: commit, then a command inside the busy window
    ev(0); sendb(8'hA0, 1, "R8 cmd"); sendb(8'h10, 1, "R8 addr"); ev(1);
    sendb(8'hA0, 1, "R8 cmd2"); sendb(8'h03, 1, "R8 ctrl");
    for (int i = 0; i < 8; i++) sendb(mem[16 + i], 1, "R8 data");
    ev(2); fm[2] = 0;
    chk("R8 flags", prot_flags, fm);
    ev(0); sendb(8'hA0, 0, "R8 busy nack"); ev(2);
    chk("R8 still busy", busy, 1);
    repeat (BC + 2) @(posedge clk);
    run(8'hA0, 8'hA0, 8'h10, 8'h01, 8, -1, 0, "R8 after busy");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule